// File: doc/BRIEF.md
# SQE test and jabber controller

This block supervises the transmit side of a 10 Mb/s twisted-pair port. It watches the transmit enable line coming from the MAC. When a frame ends, it places a short signal-quality test pulse on the collision output. The MAC uses this pulse to confirm that the collision path works. It also guards the line against a transmitter that never stops. If enable is held high for longer than the trip time (20 ms in the default configuration), the block removes permission to transmit and holds collision high. Permission returns only after enable has stayed low for the full quiet time (250 ms by default).

All time limits are parameters. The trip and quiet limits are computed from the clock rate in kHz and a duration in milliseconds, so a testbench can scale them down. The test pulse waits a parameterized number of clocks after enable falls, then lasts a parameterized number of clocks. The block has no collision input and does not report collisions caused by receive activity.

Top module: `sqe_jabber_ctl`

## Requirements
- R1: While and right after reset, `col_o` is 0 and `xmit_ok_o` is 1.
- R2: When `tx_en_i` is sampled low on the edge after it was sampled high, and the transmitter is not locked out, `col_o` stays 0 on that edge and the next SQE_GAP-1 edges. It is then 1 for exactly SQE_LEN cycles and returns to 0.
- R3: Let TRIP = CLK_KHZ*TRIP_MS. The lockout starts on the edge that samples `tx_en_i` high for the (TRIP+1)-th consecutive time. From that edge, `xmit_ok_o` is 0 and `col_o` is 1.
- R4: During lockout, `col_o` stays 1 and `xmit_ok_o` stays 0, whatever the level of `tx_en_i`, until the release of R5.
- R5: Let QUIET = CLK_KHZ*QUIET_MS. The lockout ends on the edge that samples `tx_en_i` low for the (QUIET+1)-th consecutive time. From that edge, `xmit_ok_o` is 1 and `col_o` is 0.
- R6: During lockout, one high sample of `tx_en_i` restarts the quiet count from zero. QUIET low samples followed by a high sample therefore do not release.
- R7: No test pulse is issued for a frame that ends during lockout, neither during the lockout nor after the release.
- R8: A frame with exactly TRIP high samples does not trip the lockout and is followed by a normal test pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| col_o | output | 1 | Collision indication: test pulse or lockout |
| xmit_ok_o | output | 1 | 1 = transmitter may drive the line, 0 = locked out |

## Verification
A wrong lockout bit shows at the ports on the very next cycle: `xmit_ok_o` and `col_o` disagree with the history of `tx_en_i`. An off-by-one in either run counter moves the trip or release edge by exactly one cycle. The bench looks for this at the boundary sample, where TRIP or QUIET is reached but not exceeded. A wrong pulse state or count appears within SQE_GAP+SQE_LEN cycles of a falling enable, as a shifted, stretched or missing pulse. A pulse that was not cancelled during lockout appears as collision activity just after the release.

// File: rtl/sqe_jab_pkg.sv
package sqe_jab_pkg;

    // Phases of the post-frame test pulse generator
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_WAIT = 2'd1,
        PG_FIRE = 2'd2
    } pg_state_e;

    // Supervisory outputs grouped as one word
    typedef struct packed {
        logic locked;
        logic sqe;
    } sup_state_t;

    // Clock cycles for a duration in milliseconds at a rate given in kHz
    function automatic int unsigned ms_to_cycles(int unsigned khz, int unsigned ms);
        return khz * ms;
    endfunction

    // Bits needed to hold values 0..lim
    function automatic int unsigned cnt_width(int unsigned lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/sqe_run_timer.sv
module sqe_run_timer #(
    parameter int unsigned LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic over_o
);
    localparam int unsigned W = sqe_jab_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] run_q;

    // Consecutive samples of level_i, saturating at LIMIT
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!level_i) begin
            run_q <= '0;
        end else if (run_q != LIM) begin
            run_q <= run_q + 1'b1;
        end
    end

    // The current sample is the (LIMIT+1)-th consecutive one or later
    assign over_o = level_i && (run_q == LIM);

    // R3/R5: counter never passes its limit
    p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run_q <= LIM);

    // R6: a broken run always restarts the count from zero
    p_run_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !level_i |=> (run_q == '0));

endmodule

// File: rtl/sqe_pulse_gen.sv
module sqe_pulse_gen #(
    parameter int unsigned GAP = 4,
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic kill_i,
    output logic pulse_o
);
    import sqe_jab_pkg::*;

    localparam int unsigned MAXC = (GAP > LEN) ? GAP : LEN;
    localparam int unsigned CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] GAP_END = CW'(GAP - 1);
    localparam logic [CW-1:0] LEN_END = CW'(LEN - 1);

    pg_state_e    st_q;
    logic [CW-1:0] cnt_q;

    // Priority: kill, then start (restarts timing), then progression
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PG_IDLE;
            cnt_q <= '0;
        end else if (kill_i) begin
            st_q  <= PG_IDLE;
            cnt_q <= '0;
        end else if (start_i) begin
            st_q  <= PG_WAIT;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                PG_WAIT: begin
                    if (cnt_q == GAP_END) begin
                        st_q  <= PG_FIRE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PG_FIRE: begin
                    if (cnt_q == LEN_END) begin
                        st_q  <= PG_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= PG_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign pulse_o = (st_q == PG_FIRE);

    // R2: the pulse follows the end of the gap
    p_gap_then_fire_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PG_WAIT && cnt_q == GAP_END && !kill_i && !start_i) |=> pulse_o);

    // R2: the pulse ends after its length
    p_fire_ends_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PG_FIRE && cnt_q == LEN_END && !kill_i && !start_i) |=> !pulse_o);

    // R7: a kill clears any pending or active pulse
    p_kill_clears_r7: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> (st_q == PG_IDLE));

endmodule

// File: rtl/sqe_jabber_ctl.sv
module sqe_jabber_ctl #(
    parameter int unsigned CLK_KHZ  = 20000,
    parameter int unsigned TRIP_MS  = 20,
    parameter int unsigned QUIET_MS = 250,
    parameter int unsigned SQE_GAP  = 10,
    parameter int unsigned SQE_LEN  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en_i,
    output logic col_o,
    output logic xmit_ok_o
);
    import sqe_jab_pkg::*;

    localparam int unsigned TRIP_CYC  = ms_to_cycles(CLK_KHZ, TRIP_MS);
    localparam int unsigned QUIET_CYC = ms_to_cycles(CLK_KHZ, QUIET_MS);

    logic       tx_prev_q;
    logic       fall;
    logic       hi_over;
    logic       lo_over;
    logic       locked_q;
    logic       sqe_start;
    sup_state_t sup;

    always_ff @(posedge clk) begin
        if (rst) tx_prev_q <= 1'b0;
        else     tx_prev_q <= tx_en_i;
    end

    assign fall = tx_prev_q && !tx_en_i;

    sqe_run_timer #(.LIMIT(TRIP_CYC)) u_hi_run (
        .clk     (clk),
        .rst     (rst),
        .level_i (tx_en_i),
        .over_o  (hi_over)
    );

    sqe_run_timer #(.LIMIT(QUIET_CYC)) u_lo_run (
        .clk     (clk),
        .rst     (rst),
        .level_i (!tx_en_i),
        .over_o  (lo_over)
    );

    // Lockout state: set by an over-long frame, cleared by a full quiet period
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
        end else if (!locked_q && hi_over) begin
            locked_q <= 1'b1;
        end else if (locked_q && lo_over) begin
            locked_q <= 1'b0;
        end
    end

    assign sqe_start = fall && !locked_q;

    sqe_pulse_gen #(.GAP(SQE_GAP), .LEN(SQE_LEN)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .start_i (sqe_start),
        .kill_i  (locked_q),
        .pulse_o (sup.sqe)
    );

    assign sup.locked = locked_q;
    assign col_o      = sup.locked | sup.sqe;
    assign xmit_ok_o  = !sup.locked;

    // R4: lockout always shows as collision
    p_lock_col_r4: assert property (@(posedge clk) disable iff (rst)
        !xmit_ok_o |-> col_o);

    // R3: an over-long run trips the lockout on the next cycle
    p_trip_r3: assert property (@(posedge clk) disable iff (rst)
        (xmit_ok_o && hi_over) |=> !xmit_ok_o);

    // R4/R6: a high enable never releases the lockout
    p_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
        (!xmit_ok_o && tx_en_i) |=> !xmit_ok_o);

    // R5/R7: release brings both outputs to idle, with no stale pulse
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (!xmit_ok_o && lo_over) |=> (xmit_ok_o && !col_o));

endmodule

// File: tb/sqe_jabber_ctl_test.sv
module sqe_jabber_ctl_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned KHZ   = 1;
    localparam int unsigned T_MS  = 20;
    localparam int unsigned Q_MS  = 25;
    localparam int unsigned GAP   = 3;
    localparam int unsigned LEN   = 2;
    localparam int unsigned TRIP  = KHZ * T_MS;
    localparam int unsigned QUIET = KHZ * Q_MS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0;
    logic col;
    logic xmit_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sqe_jabber_ctl #(
        .CLK_KHZ  (KHZ),
        .TRIP_MS  (T_MS),
        .QUIET_MS (Q_MS),
        .SQE_GAP  (GAP),
        .SQE_LEN  (LEN)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .tx_en_i   (tx_en),
        .col_o     (col),
        .xmit_ok_o (xmit_ok)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp_col, input logic exp_ok);
        n_cmp++;
        if (col !== exp_col || xmit_ok !== exp_ok) begin
            n_bad++;
            $display("FAIL %s at %0t: col=%b xmit_ok=%b expected col=%b xmit_ok=%b",
                     req, $time, col, xmit_ok, exp_col, exp_ok);
        end
    endtask

    // One frame of len high samples, then the pulse window
    task automatic frame(input int len, input string req_pulse);
        tx_en = 1'b1;
        for (int i = 1; i <= len; i++) begin
            tick();
            chk("R8 frame within trip limit", 1'b0, 1'b1);
        end
        tx_en = 1'b0;
        for (int i = 0; i <= int'(GAP + LEN + 1); i++) begin
            tick();
            chk(req_pulse, (i >= int'(GAP)) && (i < int'(GAP + LEN)), 1'b1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R1..all): run expired, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1 during reset", 1'b0, 1'b1);
        rst = 1'b0;
        tick();
        chk("R1 after reset", 1'b0, 1'b1);
        tick();
        chk("R1 idle", 1'b0, 1'b0 + 1'b1);

        // R2/R8: sweep every frame length up to the trip boundary
        for (int len = 1; len <= int'(TRIP); len++) begin
            frame(len, "R2 test pulse timing");
        end

        // R3: trip exactly on the (TRIP+1)-th high sample
        tx_en = 1'b1;
        for (int i = 1; i <= int'(TRIP); i++) begin
            tick();
            chk("R3 before trip", 1'b0, 1'b1);
        end
        tick();
        chk("R3 trip point", 1'b1, 1'b0);

        // R4: held while enable stays high
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R4 lockout held", 1'b1, 1'b0);
        end

        // R6: aborted quiet periods, including the full QUIET boundary
        for (int k = 0; k < 3; k++) begin
            int lows;
            lows = (k == 0) ? 1 : ((k == 1) ? int'(QUIET / 2) : int'(QUIET));
            tx_en = 1'b0;
            for (int i = 0; i < lows; i++) begin
                tick();
                chk("R6 quiet in progress", 1'b1, 1'b0);
            end
            tx_en = 1'b1;
            tick();
            chk("R6 quiet aborted", 1'b1, 1'b0);
            tick();
            chk("R4 lockout after abort", 1'b1, 1'b0);
        end

        // R5: release on the (QUIET+1)-th low sample
        tx_en = 1'b0;
        for (int i = 0; i < int'(QUIET); i++) begin
            tick();
            chk("R5 before release", 1'b1, 1'b0);
        end
        tick();
        chk("R5 release point", 1'b0, 1'b1);

        // R7: no test pulse for the frame that ended in lockout
        for (int i = 0; i < int'(GAP + LEN + 3); i++) begin
            tick();
            chk("R7 no pulse after lockout", 1'b0, 1'b1);
        end

        // R2: normal operation resumes after release
        frame(5, "R2 pulse after release");
        frame(int'(TRIP), "R8 boundary frame pulse");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule